// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes received frames from a byte stream and stores them in memory through a chain of buffer descriptors that software prepares. Each descriptor takes two 32-bit words. The first word holds the status flags in bits 31:16 and the byte count in bits 15:0. The second word holds the byte address of the data buffer. A frame arrives on a valid/ready byte stream, already followed by its four check bytes. Its total byte count, check bytes included, is given on a sideband input. That input is held stable while the frame is offered and must be at least 1.

Before it takes the first byte, the engine walks the ring to make sure that enough descriptors are marked empty to hold the frame. It then splits the bytes into buffers of the programmed size. After each buffer it writes back the descriptor's count and status and pulses an event. At the end of a frame it reloads the receive-active flag from the next descriptor.

Software reaches five registers over a simple write/read port. Data bytes go to memory as single-byte writes. Descriptor words are read and written whole. The memory answers a read on the cycle after the request.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the control register reads 0, the ring start reads 0, the buffer size reads 0x7F0, the receive control register reads 0x05EE0001, and `rx_active` is 0.
- R2: The buffer size register (address 3) keeps only bits 0x7F0 of a written value. If the masked value is zero, the register takes 0x7F0.
- R3: The receive control register (address 4) keeps only bits 0x07FF003F of a written value. Bits 31:16 are the frame length limit.
- R4: A write to the activate register (address 1) sets `rx_active` only if the enable bit (bit 0 of the control register, address 0) is set and the current descriptor has its empty flag set (flag bit 15, word bit 31). The activate register reads back `rx_active` in bit 24.
- R5: A frame is accepted only if the descriptors walked from the current one, each counted as one buffer size, are all empty and cover the whole frame. Otherwise `s_tready` stays low and nothing is written to memory, and the check is retried until descriptors are freed.
- R6: Accepted bytes are written in stream order into successive buffers, at most one buffer size per buffer. A byte at an address with low bits k goes to strobe lane 3-k (`mem_wstrb` bit i enables data bits 8i+7:8i).
- R7: Each used descriptor gets its first word rewritten with the placed byte count and the empty flag cleared, with the other flags kept. The final descriptor also gets the last flag (bit 11) and pulses `ev_frame`; every other descriptor pulses `ev_buf`.
- R8: The next descriptor is at the current address plus 8, or at the ring start when the wrap flag (bit 13) is set.
- R9: A frame whose total length exceeds 2032 is cut to 2032 bytes. Its final descriptor gets the truncated flag (bit 0) and the too-long flag (bit 5), and the excess bytes are taken from the stream and dropped.
- R10: A frame whose total length exceeds the frame length limit gets the too-long flag (bit 5) on its final descriptor.
- R11: After a frame, `rx_active` equals the enable bit ANDed with the empty flag of the next descriptor. Clearing the enable bit drops `rx_active` on the next cycle.
- R12: Writing the ring start register (address 2) stores the value with bits 1:0 cleared and makes it the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 activate, 2 ring start, 3 buffer size, 4 receive control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| s_tdata | input | 8 | Stream byte |
| s_tvalid | input | 1 | Stream byte valid |
| s_tlast | input | 1 | Final byte of the frame |
| s_tuser | input | 16 | Total frame length in bytes, check bytes included |
| s_tready | output | 1 | Engine takes the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ev_frame | output | 1 | Pulse: final descriptor of a frame written |
| ev_buf | output | 1 | Pulse: non-final descriptor written |
| rx_active | output | 1 | Receive-active flag |

## Verification
The hardest case to reach is a refusal that happens only because the ring wraps back onto a descriptor still full from an earlier frame. The bench leaves the first frame's descriptors full and then offers a second frame long enough to wrap past the ring's end. It holds the frame pending while it checks that `s_tready` stays low and no memory writes happen. It then frees the blocking descriptor behind the engine's back and checks that the retried walk accepts the frame and scatters it across the wrap.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    localparam logic [15:0] FLG_EMPTY = 16'h8000;
    localparam logic [15:0] FLG_WRAP  = 16'h2000;
    localparam logic [15:0] FLG_LAST  = 16'h0800;
    localparam logic [15:0] FLG_LONG  = 16'h0020;
    localparam logic [15:0] FLG_TRUNC = 16'h0001;

    localparam int DESC_BYTES = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK_RD,
        ST_CHK_EV,
        ST_RD_FLG,
        ST_RD_PTR,
        ST_GET_PTR,
        ST_DATA,
        ST_WBACK,
        ST_DRAIN,
        ST_EV_RD,
        ST_EV_CHK
    } rx_state_e;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_ACT   = 3'd1,
        RA_RING  = 3'd2,
        RA_BUFSZ = 3'd3,
        RA_RCTL  = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
    import rx_ring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          rx_active,
    output logic          en,
    output logic          en_clr,
    output logic          act_req,
    output logic [AW-1:0] ring_start,
    output logic          ring_load,
    output logic [AW-1:0] ring_new,
    output logic [15:0]   bufsz,
    output logic [15:0]   len_limit
);

    localparam logic [15:0] BUFSZ_MASK  = 16'h07F0;
    localparam logic [31:0] RCTL_MASK   = 32'h07FF_003F;
    localparam logic [31:0] RCTL_RESET  = 32'h05EE_0001;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] ring;
        logic [15:0]   bufsz;
        logic [31:0]   rctl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:  r_d.en = reg_wdata[0];
                RA_RING:  r_d.ring = {reg_wdata[AW-1:2], 2'b00};
                RA_BUFSZ: r_d.bufsz = ((reg_wdata[15:0] & BUFSZ_MASK) == 16'h0)
                                      ? BUFSZ_MASK : (reg_wdata[15:0] & BUFSZ_MASK);
                RA_RCTL:  r_d.rctl = reg_wdata & RCTL_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.en    <= 1'b0;
            r_q.ring  <= '0;
            r_q.bufsz <= BUFSZ_MASK;
            r_q.rctl  <= RCTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {31'b0, r_q.en};
            RA_ACT:   reg_rdata = {7'b0, rx_active, 24'b0};
            RA_RING:  reg_rdata = 32'(r_q.ring);
            RA_BUFSZ: reg_rdata = {16'b0, r_q.bufsz};
            RA_RCTL:  reg_rdata = r_q.rctl;
            default:  reg_rdata = 32'h0;
        endcase
    end

    assign en         = r_q.en;
    assign en_clr     = reg_wr && (reg_addr == RA_CTRL) && !reg_wdata[0];
    assign act_req    = reg_wr && (reg_addr == RA_ACT);
    assign ring_start = r_q.ring;
    assign ring_load  = reg_wr && (reg_addr == RA_RING);
    assign ring_new   = {reg_wdata[AW-1:2], 2'b00};
    assign bufsz      = r_q.bufsz;
    assign len_limit  = r_q.rctl[31:16];

endmodule

// File: rtl/rx_ring_fsm.sv
module rx_ring_fsm
    import rx_ring_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          en_clr,
    input  logic          act_req,
    input  logic [AW-1:0] ring_start,
    input  logic          ring_load,
    input  logic [AW-1:0] ring_new,
    input  logic [15:0]   bufsz,
    input  logic [15:0]   len_limit,
    input  logic [7:0]    s_tdata,
    input  logic          s_tvalid,
    input  logic          s_tlast,
    input  logic [15:0]   s_tuser,
    output logic          s_tready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_wstrb,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          ev_frame,
    output logic          ev_buf,
    output logic          active
);

    localparam logic [15:0]   MAXF_L = 16'(MAX_FRAME);
    localparam logic [AW-1:0] STEP   = AW'(DESC_BYTES);

    typedef struct packed {
        rx_state_e     st;
        logic          act;
        logic [AW-1:0] cur;
        logic [AW-1:0] walk;
        logic [AW-1:0] ptr;
        logic [15:0]   tot;
        logic [15:0]   rem;
        logic [15:0]   left;
        logic [15:0]   cnt;
        logic [15:0]   flg;
        logic [15:0]   err;
        logic          trunc;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [15:0]   flg_new;
    logic [15:0]   err_new;
    logic [AW-1:0] byte_addr;
    logic          over_max;

    always_comb begin
        s_d       = s_q;
        s_tready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = s_q.cur;
        mem_wstrb = 4'h0;
        mem_wdata = 32'h0;
        ev_frame  = 1'b0;
        ev_buf    = 1'b0;
        over_max  = s_tuser > MAXF_L;
        err_new   = (over_max ? (FLG_TRUNC | FLG_LONG) : 16'h0)
                  | ((s_tuser > len_limit) ? FLG_LONG : 16'h0);
        byte_addr = s_q.ptr + AW'(s_q.cnt);
        flg_new   = (s_q.flg & ~FLG_EMPTY)
                  | ((s_q.rem == 16'h0) ? (FLG_LAST | s_q.err) : 16'h0);

        if (ring_load && s_q.st == ST_IDLE) begin
            s_d.cur = ring_new;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (act_req && en && !s_q.act) begin
                    s_d.st = ST_EV_RD;
                end else if (s_q.act && s_tvalid) begin
                    s_d.tot   = over_max ? MAXF_L : s_tuser;
                    s_d.rem   = over_max ? MAXF_L : s_tuser;
                    s_d.trunc = over_max;
                    s_d.err   = err_new;
                    s_d.walk  = s_q.cur;
                    s_d.st    = ST_CHK_RD;
                end
            end
            ST_CHK_RD: begin
                mem_req  = 1'b1;
                mem_addr = s_q.walk;
                s_d.st   = ST_CHK_EV;
            end
            ST_CHK_EV: begin
                if (!mem_rdata[31]) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.rem <= bufsz) begin
                    s_d.rem = s_q.tot;
                    s_d.st  = ST_RD_FLG;
                end else begin
                    s_d.rem  = s_q.rem - bufsz;
                    s_d.walk = mem_rdata[29] ? ring_start : s_q.walk + STEP;
                    s_d.st   = ST_CHK_RD;
                end
            end
            ST_RD_FLG: begin
                mem_req  = 1'b1;
                s_d.left = (s_q.rem < bufsz) ? s_q.rem : bufsz;
                s_d.st   = ST_RD_PTR;
            end
            ST_RD_PTR: begin
                s_d.flg  = mem_rdata[31:16];
                mem_req  = 1'b1;
                mem_addr = s_q.cur + AW'(4);
                s_d.st   = ST_GET_PTR;
            end
            ST_GET_PTR: begin
                s_d.ptr = mem_rdata[AW-1:0];
                s_d.cnt = 16'h0;
                s_d.st  = ST_DATA;
            end
            ST_DATA: begin
                s_tready = 1'b1;
                if (s_tvalid) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_wstrb = 4'b1000 >> byte_addr[1:0];
                    mem_wdata = {4{s_tdata}};
                    s_d.cnt   = s_q.cnt + 16'h1;
                    s_d.rem   = s_q.rem - 16'h1;
                    if (s_q.cnt == s_q.left - 16'h1) begin
                        s_d.st = ST_WBACK;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wstrb = 4'hF;
                mem_wdata = {flg_new, s_q.cnt};
                ev_frame  = (s_q.rem == 16'h0);
                ev_buf    = (s_q.rem != 16'h0);
                s_d.cur   = ((s_q.flg & FLG_WRAP) != 16'h0) ? ring_start : s_q.cur + STEP;
                if (s_q.rem != 16'h0) begin
                    s_d.st = ST_RD_FLG;
                end else if (s_q.trunc) begin
                    s_d.st = ST_DRAIN;
                end else begin
                    s_d.st = ST_EV_RD;
                end
            end
            ST_DRAIN: begin
                s_tready = 1'b1;
                if (s_tvalid && s_tlast) begin
                    s_d.st = ST_EV_RD;
                end
            end
            ST_EV_RD: begin
                mem_req = 1'b1;
                s_d.st  = ST_EV_CHK;
            end
            ST_EV_CHK: begin
                s_d.act = en && mem_rdata[31];
                s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (en_clr) begin
            s_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.act;

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rx_ring_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [7:0]    s_tdata,
    input  logic          s_tvalid,
    input  logic          s_tlast,
    input  logic [15:0]   s_tuser,
    output logic          s_tready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_wstrb,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          ev_frame,
    output logic          ev_buf,
    output logic          rx_active
);

    logic          en_w;
    logic          en_clr_w;
    logic          act_req_w;
    logic [AW-1:0] ring_start_w;
    logic          ring_load_w;
    logic [AW-1:0] ring_new_w;
    logic [15:0]   bufsz_w;
    logic [15:0]   limit_w;

    rx_ring_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rx_active  (rx_active),
        .en         (en_w),
        .en_clr     (en_clr_w),
        .act_req    (act_req_w),
        .ring_start (ring_start_w),
        .ring_load  (ring_load_w),
        .ring_new   (ring_new_w),
        .bufsz      (bufsz_w),
        .len_limit  (limit_w)
    );

    rx_ring_fsm #(.AW(AW), .MAX_FRAME(MAX_FRAME)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_w),
        .en_clr     (en_clr_w),
        .act_req    (act_req_w),
        .ring_start (ring_start_w),
        .ring_load  (ring_load_w),
        .ring_new   (ring_new_w),
        .bufsz      (bufsz_w),
        .len_limit  (limit_w),
        .s_tdata    (s_tdata),
        .s_tvalid   (s_tvalid),
        .s_tlast    (s_tlast),
        .s_tuser    (s_tuser),
        .s_tready   (s_tready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wstrb  (mem_wstrb),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .ev_frame   (ev_frame),
        .ev_buf     (ev_buf),
        .active     (rx_active)
    );

endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [3:0]  mem_wstrb,
    input logic [31:0] mem_wdata,
    input logic        ev_frame,
    input logic        ev_buf,
    input logic        rx_active,
    input logic        en,
    input logic [15:0] bufsz
);

    // R2: buffer size is always a nonzero multiple of 16 within 0x7F0
    a_r2_bufsz_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (bufsz[3:0] == 4'h0) && (bufsz != 16'h0) && (bufsz <= 16'h07F0));

    // R7: buffer and frame events never coincide
    a_r7_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_frame && ev_buf));

    // R7: frame event comes with a full-word write carrying last, empty cleared
    a_r7_last_marked: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |-> (mem_req && mem_we && mem_wstrb == 4'hF && mem_wdata[27] && !mem_wdata[31]));

    // R7: buffer event writes a descriptor without last, empty cleared
    a_r7_mid_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf |-> (mem_req && mem_we && !mem_wdata[27] && !mem_wdata[31]));

    // R6: single-byte writes only on a stream handshake
    a_r6_byte_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_wstrb) == 1) |-> (s_tvalid && s_tready));

    // R11: receive is never active while disabled
    a_r11_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !rx_active);

    // R11: clearing the enable bit drops the flag on the next cycle
    a_r11_drop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> !rx_active);

endmodule

bind rx_ring_engine rx_ring_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tvalid  (s_tvalid),
    .s_tready  (s_tready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wstrb (mem_wstrb),
    .mem_wdata (mem_wdata),
    .ev_frame  (ev_frame),
    .ev_buf    (ev_buf),
    .rx_active (rx_active),
    .en        (en_w),
    .bufsz     (bufsz_w)
);

// File: tb/rx_ring_engine_bench.sv
`timescale 1ns/1ps
module rx_ring_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [7:0]  s_tdata = 8'h0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic [15:0] s_tuser = 16'h0;
    logic        s_tready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        ev_frame, ev_buf, rx_active;

    always #4 clk = ~clk;

    rx_ring_engine u_rx_ring_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_tdata(s_tdata),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tuser(s_tuser),
        .s_tready(s_tready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ev_frame(ev_frame), .ev_buf(ev_buf),
        .rx_active(rx_active)
    );

    logic [31:0] mem     [0:1023];
    logic [31:0] ref_mem [0:1023];
    int nchk = 0, nerr = 0;
    int n_frame = 0, n_buf = 0, n_we = 0;
    int exp_frame = 0, exp_buf = 0;
    int m_cur = 0, m_ring = 0, m_mbs = 16'h7F0, m_limit = 16'h05EE, m_en = 0;
    int seed = 1;
    bit done = 0;

    // memory model: one-cycle read latency, byte strobes
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (ev_frame) n_frame++;
            if (ev_buf) n_buf++;
            if (mem_req && mem_we) n_we++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        summary();
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            3'd0: begin m_en = d[0]; end
            3'd2: begin m_ring = {d[31:2], 2'b00}; m_cur = m_ring; end
            3'd3: m_mbs = ((d & 32'h7F0) == 0) ? 32'h7F0 : (d & 32'h7F0);
            3'd4: m_limit = (d & 32'h07FF003F) >> 16;
            default: ;
        endcase
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] fbyte(input int i);
        return 8'((seed * 13 + i * 7) & 8'hFF);
    endfunction

    task automatic ref_byte(input int a, input logic [7:0] b);
        ref_mem[a >> 2][(3 - (a & 3)) * 8 +: 8] = b;
    endtask

    // ring of n descriptors at 0x100, buffers of 64-byte stride from bufbase
    task automatic setup_ring(input int n, input int bufbase);
        for (int k = 0; k < n; k++) begin
            mem[(32'h100 >> 2) + 2*k]     = {16'h8000 | ((k == n-1) ? 16'h2000 : 16'h0), 16'h0};
            mem[(32'h100 >> 2) + 2*k + 1] = bufbase + 64*k;
        end
        for (int w = 0; w < 1024; w++) ref_mem[w] = mem[w];
        reg_write(3'd2, 32'h100);
    endtask

    // behavioural reference: returns 1 if the frame fits, then updates ref_mem
    task automatic model_frame(input int len, output bit ok);
        int tot, fl, a, rem, ch, idx, f, p;
        tot = (len > 2032) ? 2032 : len;
        fl = 0;
        if (len > 2032) fl = 32'h21;
        if (len > m_limit) fl = fl | 32'h20;
        a = m_cur; rem = tot; ok = 0;
        for (int g = 0; g < 64; g++) begin
            f = ref_mem[a >> 2][31:16];
            if (!f[15]) break;
            if (rem <= m_mbs) begin ok = 1; break; end
            rem = rem - m_mbs;
            a = f[13] ? m_ring : a + 8;
        end
        if (ok) begin
            a = m_cur; rem = tot; idx = 0;
            while (rem > 0) begin
                ch = (rem < m_mbs) ? rem : m_mbs;
                p = ref_mem[(a >> 2) + 1];
                for (int k = 0; k < ch; k++) begin
                    ref_byte(p + k, fbyte(idx));
                    idx++;
                end
                rem = rem - ch;
                f = ref_mem[a >> 2][31:16] & 32'h7FFF;
                if (rem == 0) begin f = f | 32'h800 | fl; exp_frame++; end
                else exp_buf++;
                ref_mem[a >> 2] = {f[15:0], ch[15:0]};
                a = f[13] ? m_ring : a + 8;
            end
            m_cur = a;
        end
    endtask

    task automatic send(input int len);
        int i;
        bit rdy;
        i = 0;
        s_tuser = 16'(len);
        while (i < len) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = fbyte(i);
            s_tlast  = (i == len - 1);
            rdy = s_tready;
            @(posedge clk);
            if (rdy) i++;
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        repeat (8) @(negedge clk);
        seed++;
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        bad = 0;
        for (int w = 0; w < 1024; w++) if (mem[w] !== ref_mem[w]) bad++;
        chk(tag, bad, 0);
    endtask

    function automatic bit exp_active();
        return (m_en != 0) && ref_mem[m_cur >> 2][31];
    endfunction

    logic [31:0] rd;
    bit ok;
    int we0, rdy_cnt;

    initial begin
        for (int w = 0; w < 1024; w++) begin mem[w] = 32'h0; ref_mem[w] = 32'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        reg_read(3'd0, rd); chk("R1 ctrl reset", rd, 32'h0);
        reg_read(3'd2, rd); chk("R1 ring reset", rd, 32'h0);
        reg_read(3'd3, rd); chk("R1 bufsz reset", rd, 32'h7F0);
        reg_read(3'd4, rd); chk("R1 rctl reset", rd, 32'h05EE0001);
        chk("R1 rx_active reset", rx_active, 1'b0);

        // R2 buffer size masking
        reg_write(3'd3, 32'h0);    reg_read(3'd3, rd); chk("R2 zero selects 0x7F0", rd, 32'h7F0);
        reg_write(3'd3, 32'h1234); reg_read(3'd3, rd); chk("R2 masked 0x1234", rd, 32'h230);
        reg_write(3'd3, 32'h8);    reg_read(3'd3, rd); chk("R2 masked to zero", rd, 32'h7F0);
        reg_write(3'd3, 32'h40);   reg_read(3'd3, rd); chk("R2 size 64", rd, 32'h40);

        // R3 receive control masking
        reg_write(3'd4, 32'hFFFFFFFF); reg_read(3'd4, rd); chk("R3 rctl mask", rd, 32'h07FF003F);
        reg_write(3'd4, 32'h05EE0001);

        // R12 ring start
        reg_write(3'd2, 32'h107); reg_read(3'd2, rd); chk("R12 ring low bits cleared", rd, 32'h104);
        reg_write(3'd2, 32'h100);

        // R4 activation rules
        reg_write(3'd1, 32'h0); repeat (4) @(negedge clk);
        reg_read(3'd1, rd); chk("R4 activate while disabled", rd, 32'h0);
        reg_write(3'd0, 32'h1);
        reg_write(3'd1, 32'h0); repeat (4) @(negedge clk);
        reg_read(3'd1, rd); chk("R4 activate on full descriptor", rd, 32'h0);
        setup_ring(4, 32'h400);
        reg_write(3'd1, 32'h0); repeat (4) @(negedge clk);
        reg_read(3'd1, rd); chk("R4 activate readback bit 24", rd, 32'h01000000);
        chk("R4 rx_active set", rx_active, 1'b1);

        // R6 R7 R8: 100-byte frame over two 64-byte buffers
        model_frame(100, ok); chk("R5 model accepts frame A", ok, 1'b1);
        send(100);
        cmp_mem("R6 R7 R8 frame A memory image");
        chk("R7 frame events A", n_frame, exp_frame);
        chk("R7 buffer events A", n_buf, exp_buf);
        chk("R11 active after frame A", rx_active, exp_active());

        // R5: 150 bytes would wrap onto full descriptor 0 -> refused
        model_frame(150, ok); chk("R5 model refuses frame B", ok, 1'b0);
        we0 = n_we; rdy_cnt = 0;
        @(negedge clk);
        s_tuser = 16'd150; s_tvalid = 1'b1; s_tdata = fbyte(0); s_tlast = 1'b0;
        repeat (40) begin @(negedge clk); if (s_tready) rdy_cnt++; end
        chk("R5 tready held low while short of space", rdy_cnt, 0);
        chk("R5 no memory writes while refused", n_we - we0, 0);
        mem[32'h100 >> 2]     = 32'h80000000;
        ref_mem[32'h100 >> 2] = 32'h80000000;
        model_frame(150, ok); chk("R5 model accepts after free", ok, 1'b1);
        send(150);
        cmp_mem("R5 R8 frame B wraps over ring end");
        chk("R7 frame events B", n_frame, exp_frame);
        chk("R7 buffer events B", n_buf, exp_buf);
        chk("R11 inactive when next descriptor full", rx_active, 1'b0);
        chk("R11 model agrees inactive", exp_active(), 1'b0);

        // R10 length limit 64
        reg_write(3'd4, 32'h00400001);
        setup_ring(4, 32'h400);
        reg_write(3'd1, 32'h0); repeat (4) @(negedge clk);
        model_frame(80, ok); send(80);
        cmp_mem("R10 too-long flag above limit");
        chk("R10 last descriptor long flag", mem[(32'h100 >> 2) + 2][21], 1'b1);
        model_frame(60, ok); send(60);
        cmp_mem("R10 no flag within limit");
        chk("R10 short frame flags", mem[(32'h100 >> 2) + 4][31:16], 16'h0800);
        reg_write(3'd4, 32'h05EE0001);

        // R9 truncation with one 2032-byte buffer
        reg_write(3'd3, 32'h0);
        mem[32'h100 >> 2] = {16'hA000, 16'h0};
        mem[(32'h100 >> 2) + 1] = 32'h800;
        for (int w = 0; w < 1024; w++) ref_mem[w] = mem[w];
        reg_write(3'd2, 32'h100);
        reg_write(3'd1, 32'h0); repeat (4) @(negedge clk);
        chk("R9 active before long frame", rx_active, 1'b1);
        model_frame(2100, ok); chk("R9 model accepts long frame", ok, 1'b1);
        send(2100);
        cmp_mem("R9 truncated frame image");
        chk("R9 descriptor word", mem[32'h100 >> 2], {16'h2821, 16'd2032});
        chk("R7 frame events long", n_frame, exp_frame);
        chk("R11 inactive after single-descriptor ring", rx_active, 1'b0);

        // R11 enable clear
        reg_write(3'd3, 32'h40);
        setup_ring(4, 32'h400);
        reg_write(3'd1, 32'h0); repeat (4) @(negedge clk);
        chk("R11 active before disable", rx_active, 1'b1);
        reg_write(3'd0, 32'h0);
        chk("R11 dropped by enable clear", rx_active, 1'b0);
        reg_read(3'd1, rd); chk("R11 readback after disable", rd, 32'h0);

        summary();
    end

endmodule